// File: doc/BRIEF.md
# Serial MII Receive Deserializer (MAC side)

This block is the MAC-side receiver of a Serial MII link. It creates the frame-alignment strobe on its `sync` output: high for one clock out of every ten reference clocks. After each strobe it reads one 10-bit segment, one bit per clock, from the single receive line. The first bit of a segment is carrier sense and the second is a data-valid flag. The remaining eight bits carry either one packet byte (two MII nibbles) or a word of PHY status. When the valid flag is set, the eight bits are delivered as a byte with a one-clock strobe. When it is clear, the bits are decoded into registered PHY status flags.

At 100 Mb/s every segment is used. At 10 Mb/s the PHY repeats each segment ten times. The block then uses only one copy out of each group of ten and ignores the other nine, so each group yields a single byte. A group counter sets which copy is used. It starts over on the first segment after reset and on the first segment after the speed input drops to 10 Mb/s.

Top module: `smii_rx_deser`

## Requirements
- R1: `sync` is high for exactly one clock in every ten. It is low throughout reset and rises on the first clock edge after reset is released.
- R2: The clock in which `sync` is high is bit slot 0 of a segment. `rxd_p` is sampled at the end of slots 0 to 9, which carry in order carrier sense, data valid, then payload bits 0 to 7 (bit 0 first). A delivered byte has payload bit k at `rx_byte[k]`.
- R3: An accepted segment whose data-valid bit is 1 drives `rx_valid` high for exactly one clock. That clock is the one right after slot 9 is sampled, which is also the next `sync` clock. `rx_byte` then holds the payload.
- R4: An accepted segment whose data-valid bit is 0 raises no `rx_valid` and leaves `rx_byte` unchanged. It loads payload bits 0 to 6 into `phy_status[6:0]`. The status bits mean: bit 0 receive error in the previous frame, bit 1 speed (1 = 100 Mb/s), bit 2 duplex (1 = full), bit 3 link up, bit 4 jabber, bit 5 upper nibble valid, bit 6 false carrier.
- R5: `phy_status` changes only after an accepted status segment. Data segments leave it unchanged.
- R6: `crs` takes the carrier-sense bit of every accepted segment, updated in the same clock as `rx_valid`. It holds between accepted segments.
- R7: When `speed_100` is 0, only one segment in ten is accepted. That is the first segment after reset or after `speed_100` falls, and every tenth segment after it. The other nine have no effect on any output. When `speed_100` is 1, every segment is accepted.
- R8: A synchronous active-high reset clears `sync`, `rx_valid`, `rx_byte`, `crs`, `phy_status` and the bit and group counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| speed_100 | input | 1 | 1 = 100 Mb/s (use every segment), 0 = 10 Mb/s (one in ten) |
| rxd_p | input | 1 | Serial receive line from the PHY |
| sync | output | 1 | Segment-start strobe to the PHY |
| rx_valid | output | 1 | One-clock strobe marking a new byte |
| rx_byte | output | 8 | Last received packet byte |
| crs | output | 1 | Carrier sense from the last accepted segment |
| phy_status | output | 7 | Status flags from the last accepted status segment |

## Verification
The bench acts as the PHY. It watches `sync` and clocks out segments from a queue: directed all-zero, all-one and alternating payloads, then random mixes of data and status segments with carrier sense toggling. Payload bit patterns expose bit-order or slot-offset faults. Interleaved data and status segments show whether the data-valid bit steers each payload to the byte output or to the status register. At 10 Mb/s the bench fills the nine non-selected copies of each group with random bits, so accepting the wrong copy changes the byte, the status or the carrier flag. A switch to 100 Mb/s partway through a group, and a switch back, check that the group counter starts over.

// File: rtl/smii_rx_pkg.sv
package smii_rx_pkg;

  // One serial segment, packed so that slot k of the line is bit k.
  localparam int SEG_LEN  = 10;
  localparam int BYTE_W   = 8;
  localparam int STATUS_W = 7;

  typedef struct packed {
    logic [BYTE_W-1:0] payload; // slots 2..9
    logic              dv;      // slot 1
    logic              cs;      // slot 0
  } seg_t;

  // Status flag positions inside the payload (decoded by the MAC).
  localparam int ST_PREV_ERR   = 0;
  localparam int ST_SPEED      = 1;
  localparam int ST_DUPLEX     = 2;
  localparam int ST_LINK       = 3;
  localparam int ST_JABBER     = 4;
  localparam int ST_UPPER_OK   = 5;
  localparam int ST_FALSE_CARR = 6;

endpackage

// File: rtl/smii_rx_timing.sv
// Slot counter, sync strobe generation and 10 Mb/s group selection.
module smii_rx_timing #(
  parameter int SEG_LEN = 10,
  parameter int REPEAT  = 10,
  localparam int POS_W  = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1,
  localparam int GRP_W  = (REPEAT > 1) ? $clog2(REPEAT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             speed_100,
  output logic             sync,
  output logic             run,
  output logic [POS_W-1:0] slot,
  output logic             seg_end,
  output logic             seg_take
);

  localparam logic [POS_W-1:0] LAST_SLOT = POS_W'(SEG_LEN - 1);
  localparam logic [GRP_W-1:0] LAST_GRP  = GRP_W'(REPEAT - 1);

  logic             sync_q;
  logic             run_q;
  logic [POS_W-1:0] slot_q;
  logic [GRP_W-1:0] grp_q;
  logic             at_last;

  assign at_last = (slot_q == LAST_SLOT);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      sync_q <= 1'b0;
      slot_q <= '0;
      grp_q  <= '0;
    end else if (!run_q) begin
      // First edge after reset opens slot 0 of the first segment.
      run_q  <= 1'b1;
      sync_q <= 1'b1;
      slot_q <= '0;
    end else begin
      sync_q <= at_last;
      slot_q <= at_last ? '0 : slot_q + POS_W'(1);
      if (at_last) begin
        if (speed_100)
          grp_q <= '0;
        else
          grp_q <= (grp_q == LAST_GRP) ? '0 : grp_q + GRP_W'(1);
      end
    end
  end

  assign sync     = sync_q;
  assign run      = run_q;
  assign slot     = slot_q;
  assign seg_end  = run_q && at_last;
  assign seg_take = seg_end && (speed_100 || (grp_q == '0));

endmodule

// File: rtl/smii_rx_capture.sv
// Per-slot capture flops; the final slot is taken straight from the line.
module smii_rx_capture #(
  parameter int SEG_LEN = 10,
  localparam int POS_W  = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic [POS_W-1:0]   slot,
  input  logic               rxd_p,
  output logic [SEG_LEN-1:0] seg_word
);

  logic [SEG_LEN-2:0] held;

  for (genvar i = 0; i < SEG_LEN - 1; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        held[i] <= 1'b0;
      else if (run && (slot == POS_W'(i)))
        held[i] <= rxd_p;
    end
  end

  assign seg_word = {rxd_p, held};

endmodule

// File: rtl/smii_rx_decode.sv
// Splits an accepted segment into byte delivery or status update.
module smii_rx_decode
  import smii_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                seg_take,
  input  seg_t                seg,
  output logic                rx_valid,
  output logic [BYTE_W-1:0]   rx_byte,
  output logic                crs,
  output logic [STATUS_W-1:0] phy_status
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_valid   <= 1'b0;
      rx_byte    <= '0;
      crs        <= 1'b0;
      phy_status <= '0;
    end else begin
      rx_valid <= seg_take && seg.dv;
      if (seg_take) begin
        crs <= seg.cs;
        if (seg.dv)
          rx_byte <= seg.payload;
        else
          phy_status <= seg.payload[STATUS_W-1:0];
      end
    end
  end

endmodule

// File: rtl/smii_rx_deser.sv
module smii_rx_deser
  import smii_rx_pkg::*;
#(
  parameter int REPEAT = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                speed_100,
  input  logic                rxd_p,
  output logic                sync,
  output logic                rx_valid,
  output logic [BYTE_W-1:0]   rx_byte,
  output logic                crs,
  output logic [STATUS_W-1:0] phy_status
);

  localparam int POS_W = $clog2(SEG_LEN);

  logic             run;
  logic [POS_W-1:0] slot;
  logic             seg_end;
  logic             seg_take;
  logic [SEG_LEN-1:0] seg_word;
  seg_t             seg;

  smii_rx_timing #(.SEG_LEN(SEG_LEN), .REPEAT(REPEAT)) u_timing (
    .clk      (clk),
    .rst      (rst),
    .speed_100(speed_100),
    .sync     (sync),
    .run      (run),
    .slot     (slot),
    .seg_end  (seg_end),
    .seg_take (seg_take)
  );

  smii_rx_capture #(.SEG_LEN(SEG_LEN)) u_capture (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .slot    (slot),
    .rxd_p   (rxd_p),
    .seg_word(seg_word)
  );

  assign seg = seg_t'(seg_word);

  smii_rx_decode u_decode (
    .clk       (clk),
    .rst       (rst),
    .seg_take  (seg_take),
    .seg       (seg),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .crs       (crs),
    .phy_status(phy_status)
  );

  logic unused_end;
  assign unused_end = seg_end;

endmodule

// File: rtl/smii_rx_checks.sv
module smii_rx_checks
  import smii_rx_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                sync,
  input logic                rx_valid,
  input logic [BYTE_W-1:0]   rx_byte,
  input logic                crs,
  input logic [STATUS_W-1:0] phy_status
);

  logic [7:0] gap;
  logic       seen_sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap       <= '0;
      seen_sync <= 1'b0;
    end else if (sync) begin
      gap       <= '0;
      seen_sync <= 1'b1;
    end else begin
      gap <= gap + 8'd1;
    end
  end

  a_r1_sync_period: assert property (@(posedge clk) disable iff (rst)
    (sync && seen_sync) |-> (gap == 8'(SEG_LEN - 1)));

  a_r1_sync_single: assert property (@(posedge clk) disable iff (rst)
    sync |=> !sync);

  a_r3_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  a_r3_valid_on_sync: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> sync);

  a_r5_status_kept_on_data: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $stable(phy_status));

  a_r6_hold_off_sync: assert property (@(posedge clk) disable iff (rst)
    !sync |-> ($stable(crs) && $stable(phy_status) && $stable(rx_byte)));

endmodule

bind smii_rx_deser smii_rx_checks u_checks (
  .clk       (clk),
  .rst       (rst),
  .sync      (sync),
  .rx_valid  (rx_valid),
  .rx_byte   (rx_byte),
  .crs       (crs),
  .phy_status(phy_status)
);

// File: tb/smii_rx_deser_test.sv
module smii_rx_deser_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       speed_100 = 1'b1;
  logic       rxd_p = 1'b0;
  logic       sync;
  logic       rx_valid;
  logic [7:0] rx_byte;
  logic       crs;
  logic [6:0] phy_status;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  smii_rx_deser uut (
    .clk(clk), .rst(rst), .speed_100(speed_100), .rxd_p(rxd_p),
    .sync(sync), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .crs(crs), .phy_status(phy_status)
  );

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=0x%0h expected=0x%0h", tag, got, exp);
    end
  endtask

  function automatic logic [9:0] make_seg(input logic cs, input logic dv,
                                          input logic [7:0] pl);
    return {pl, dv, cs};
  endfunction

  // PHY model and expectation state
  logic [9:0] seg_q[$];
  logic       req_speed = 1'b1;
  logic       garbage = 1'b0;
  logic [9:0] cur_seg, tx_seg;
  int         idx = 0, copy = 0, gap = 0;
  bit         seen_sync = 0, have_prev = 0;
  logic       exp_valid = 0, exp_crs = 0;
  logic [7:0] exp_byte = 0;
  logic [6:0] exp_status = 0;
  string      tag_v = "R3", tag_s = "R5";

  always @(negedge clk) begin
    if (rst) begin
      idx = 0; copy = 0; gap = 0; seen_sync = 0; have_prev = 0;
      exp_valid = 0; exp_crs = 0; exp_byte = 0; exp_status = 0;
      tx_seg = '0; cur_seg = '0; rxd_p = 1'b0;
    end else begin
      gap++;
      if (sync) begin
        if (seen_sync) check("R1 sync period", gap, 10);
        gap = 0;
        if (have_prev) begin
          check({tag_v, " rx_valid"}, int'(rx_valid), int'(exp_valid));
          check("R2 rx_byte", int'(rx_byte), int'(exp_byte));
          check("R6 crs", int'(crs), int'(exp_crs));
          check({tag_s, " phy_status"}, int'(phy_status), int'(exp_status));
        end
        if (req_speed != speed_100) begin
          speed_100 = req_speed;
          copy = 0;
        end
        if (copy == 0) begin
          if (seg_q.size() > 0) cur_seg = seg_q.pop_front();
          else cur_seg = make_seg(1'b0, 1'b0, 8'h2E);
          tx_seg = cur_seg;
        end else begin
          tx_seg = garbage ? 10'($urandom) : cur_seg;
        end
        if (speed_100 || copy == 0) begin
          exp_valid = tx_seg[1];
          exp_crs   = tx_seg[0];
          if (tx_seg[1]) begin
            exp_byte = tx_seg[9:2];
            tag_v = "R3"; tag_s = "R5";
          end else begin
            exp_status = tx_seg[8:2];
            tag_v = "R4"; tag_s = "R4";
          end
        end else begin
          exp_valid = 1'b0;
          tag_v = "R7"; tag_s = "R7";
        end
        if (!speed_100) copy = (copy + 1) % 10;
        idx = 0;
        seen_sync = 1;
        have_prev = 1;
      end else begin
        idx++;
      end
      if (seen_sync && idx < 10) rxd_p = tx_seg[idx];
    end
  end

  task automatic push_random(input int n);
    for (int i = 0; i < n; i++)
      seg_q.push_back(10'($urandom));
  endtask

  task automatic drain(input int cycles);
    wait (seg_q.size() == 0);
    repeat (cycles) @(negedge clk);
  endtask

  task automatic check_reset_state();
    check("R8 sync", int'(sync), 0);
    check("R8 rx_valid", int'(rx_valid), 0);
    check("R8 rx_byte", int'(rx_byte), 0);
    check("R8 crs", int'(crs), 0);
    check("R8 phy_status", int'(phy_status), 0);
  endtask

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    check_reset_state();
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1 first sync after reset", int'(sync), 1);

    // Directed 100 Mb/s corners
    seg_q.push_back(make_seg(1'b1, 1'b1, 8'h00));
    seg_q.push_back(make_seg(1'b1, 1'b1, 8'hFF));
    seg_q.push_back(make_seg(1'b0, 1'b0, 8'h7F));
    seg_q.push_back(make_seg(1'b1, 1'b1, 8'hA5));
    seg_q.push_back(make_seg(1'b0, 1'b0, 8'h55));
    seg_q.push_back(make_seg(1'b1, 1'b0, 8'h2A));
    seg_q.push_back(make_seg(1'b0, 1'b1, 8'h5A));
    seg_q.push_back(make_seg(1'b1, 1'b1, 8'h01));
    seg_q.push_back(make_seg(1'b1, 1'b1, 8'h80));
    drain(30);
    push_random(60);
    drain(30);

    // 10 Mb/s with junk in the skipped copies
    #1 garbage = 1'b1; req_speed = 1'b0;
    seg_q.push_back(make_seg(1'b1, 1'b1, 8'hC3));
    seg_q.push_back(make_seg(1'b0, 1'b0, 8'h4B));
    push_random(20);
    drain(250);

    // Switch up to 100 Mb/s partway through a group, then back down
    push_random(4);
    wait (copy == 4);
    #1 req_speed = 1'b1;
    push_random(20);
    drain(30);
    #1 req_speed = 1'b0;
    push_random(8);
    drain(250);

    // Reset in the middle of traffic
    push_random(5);
    repeat (23) @(negedge clk);
    #1 rst = 1'b1;
    repeat (3) @(negedge clk);
    check_reset_state();
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1 sync after second reset", int'(sync), 1);
    drain(250);

    report();
    $finish;
  end

endmodule